// File: doc/BRIEF.md
# Memory request tag tracker

This block sits on the request side between an application and a packetized memory-link controller. A request travels through it combinationally: the application drives a request with `req_valid` and sees `req_ready`. The block passes the request to the controller side with `fwd_valid` and takes `fwd_ready` back. A request is taken on a rising clock edge when both `req_valid` and `req_ready` are high. A request may take several beats. `req_last` marks its final beat, and until that beat the tag, command, cube ID, address and posted flag must not change.

Each request that expects a response (non-posted) claims its 9-bit tag on its first accepted beat. The block keeps a bitmap of the live tags. A non-posted request whose tag is already live is held back, is not forwarded, and sets a sticky duplicate flag. A response strobe frees its tag. A response for a tag that is not live sets a separate sticky flag. A posted request neither claims a tag nor is checked against the bitmap. On its way out, the address has its low nibble cleared unless the command is the bit-write code.

Top module: `mreq_tag_guard`

## Requirements
- R1: A request beat is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` follows `fwd_ready` when no duplicate is detected, and `fwd_valid` follows `req_valid`. Tag, command and cube reach the forward side unchanged.
- R2: The first accepted beat of a non-posted request (`req_posted`=0) marks its tag live, and `live_count` rises by one in the next cycle. A request shown while `fwd_ready` is low claims nothing.
- R3: A non-posted first beat whose tag is live drives `req_ready` and `fwd_valid` low in that cycle and sets the sticky `dup_err` from the next cycle on. `live_count` does not change.
- R4: A posted request (`req_posted`=1) is forwarded even when its tag is live and leaves `live_count` unchanged.
- R5: A `rsp_valid` strobe with a live `rsp_tag` frees that tag. `live_count` falls by one and the tag can be claimed again.
- R6: A `rsp_valid` strobe with a tag that is not live sets the sticky `orphan_err` and leaves `live_count` unchanged.
- R7: When a response frees a tag in the same cycle that a non-posted request presents that tag, the free is applied first. The request is accepted, the tag stays live and `live_count` is unchanged.
- R8: Beats after the first in a multi-beat request (`req_last`=0 until the final beat) claim no tag and are not duplicate-checked.
- R9: Inside a multi-beat request, a cycle with `req_valid` low, or with any of tag, command, cube, address or posted flag different from the first beat, sets the sticky `proto_err`.
- R10: `fwd_addr` equals `req_addr` with bits 3:0 forced to zero, except when `req_cmd` equals the bit-write code `BITWR_CMD` (default 6'h11), in which case all 34 bits pass unchanged.
- R11: Two back-to-back non-posted requests carrying the same tag are separate transactions, so the second is blocked as a duplicate.
- R12: An active-low reset frees every tag, zeroes `live_count` and clears all three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request beat can be taken |
| req_posted | input | 1 | Request expects no response |
| req_last | input | 1 | Final beat of the request |
| req_tag | input | 9 | Request tag |
| req_cmd | input | 6 | Command code |
| req_cube | input | 3 | Target cube ID |
| req_addr | input | 34 | Target address |
| fwd_valid | output | 1 | Forwarded beat present |
| fwd_ready | input | 1 | Controller takes the forwarded beat |
| fwd_tag | output | 9 | Forwarded tag |
| fwd_cmd | output | 6 | Forwarded command |
| fwd_cube | output | 3 | Forwarded cube ID |
| fwd_addr | output | 34 | Normalized address |
| rsp_valid | input | 1 | Response strobe |
| rsp_tag | input | 9 | Tag of the returning response |
| live_count | output | 10 | Number of live tags |
| dup_err | output | 1 | Sticky: live tag reused |
| orphan_err | output | 1 | Sticky: response for a free tag |
| proto_err | output | 1 | Sticky: multi-beat fields changed or valid dropped |

## Verification
The hardest case to reach from the ports is a response that frees a tag in the same cycle that a new request presents that tag. The bench claims a tag, then drives `rsp_valid` and a non-posted request with the same tag in one cycle. It checks that `req_ready` stays high and that `live_count` does not move. It then sends one more response for that tag and sees the count fall, which shows the tag was still live. Multi-beat checks use a three-beat request: one run with a stalled middle beat, which must pass clean, and one with an address change on the second beat, which must raise `proto_err`.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  parameter int TAG_W  = 9;
  parameter int CMD_W  = 6;
  parameter int CUBE_W = 3;
  parameter int ADDR_W = 34;
  parameter int NIB_W  = 4;
  localparam int NTAGS = 1 << TAG_W;
  localparam int CNT_W = $clog2(NTAGS + 1);

  typedef struct packed {
    logic              posted;
    logic [TAG_W-1:0]  tag;
    logic [CMD_W-1:0]  cmd;
    logic [CUBE_W-1:0] cube;
    logic [ADDR_W-1:0] addr;
  } req_fields_t;
endpackage

// File: rtl/mreq_tag_pool.sv
module mreq_tag_pool
  import mreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] chk_tag,
  input  logic             claim,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             tag_busy,
  output logic             orphan,
  output logic [CNT_W-1:0] count
);
  logic [NTAGS-1:0] inuse_q, inuse_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             free_hit;

  // a response for the checked tag frees it before the check sees it
  assign tag_busy = inuse_q[chk_tag] & ~(rsp_valid && (rsp_tag == chk_tag));
  assign free_hit = rsp_valid & inuse_q[rsp_tag];
  assign orphan   = rsp_valid & ~inuse_q[rsp_tag];

  always_comb begin
    inuse_d = inuse_q;
    if (free_hit) inuse_d[rsp_tag] = 1'b0;
    if (claim)    inuse_d[chk_tag] = 1'b1;
    count_d = count_q;
    if (claim && !free_hit)      count_d = count_q + 1'b1;
    else if (!claim && free_hit) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inuse_q <= '0;
      count_q <= '0;
    end else if (claim || free_hit) begin
      inuse_q <= inuse_d;
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/mreq_burst_watch.sv
module mreq_burst_watch
  import mreq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        req_valid,
  input  logic        req_last,
  input  req_fields_t fields,
  output logic        in_burst,
  output logic        proto_err
);
  req_fields_t held_q, held_d;
  logic        burst_q, burst_d;
  logic        err_q, err_d;
  logic        held_en;

  assign held_en = accept & ~burst_q;

  always_comb begin
    burst_d = burst_q;
    if (accept) burst_d = ~req_last;
    held_d  = fields;
    err_d   = err_q | (burst_q & (~req_valid | (fields != held_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      burst_q <= burst_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (held_en) held_q <= held_d;
  end

  assign in_burst  = burst_q;
  assign proto_err = err_q;
endmodule

// File: rtl/mreq_addr_norm.sv
module mreq_addr_norm
  import mreq_pkg::*;
#(
  parameter logic [CMD_W-1:0] BITWR_CMD = 6'h11
)(
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic keep_low;
  assign keep_low = (cmd == BITWR_CMD);

  generate
    if (NIB_W > 0) begin : g_mask
      assign addr_out = keep_low ? addr_in
                                 : {addr_in[ADDR_W-1:NIB_W], {NIB_W{1'b0}}};
    end else begin : g_pass
      assign addr_out = addr_in;
    end
  endgenerate
endmodule

// File: rtl/mreq_tag_guard.sv
module mreq_tag_guard
  import mreq_pkg::*;
#(
  parameter logic [CMD_W-1:0] BITWR_CMD = 6'h11
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_posted,
  input  logic              req_last,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [CUBE_W-1:0] req_cube,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [CMD_W-1:0]  fwd_cmd,
  output logic [CUBE_W-1:0] fwd_cube,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic [CNT_W-1:0]  live_count,
  output logic              dup_err,
  output logic              orphan_err,
  output logic              proto_err
);
  logic        in_burst, tag_busy, orphan;
  logic        dup_block, accept, claim;
  logic        dup_q, dup_d, orph_q, orph_d;
  req_fields_t fields;

  assign fields = '{posted: req_posted, tag: req_tag, cmd: req_cmd,
                    cube: req_cube, addr: req_addr};

  assign dup_block = req_valid & ~req_posted & ~in_burst & tag_busy;
  assign req_ready = fwd_ready & ~dup_block;
  assign fwd_valid = req_valid & ~dup_block;
  assign accept    = req_valid & req_ready;
  assign claim     = accept & ~req_posted & ~in_burst;

  assign fwd_tag  = req_tag;
  assign fwd_cmd  = req_cmd;
  assign fwd_cube = req_cube;

  mreq_tag_pool u_pool (
    .clk(clk), .rst_n(rst_n), .chk_tag(req_tag), .claim(claim),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .tag_busy(tag_busy), .orphan(orphan), .count(live_count)
  );

  mreq_burst_watch u_burst (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_valid(req_valid),
    .req_last(req_last), .fields(fields),
    .in_burst(in_burst), .proto_err(proto_err)
  );

  mreq_addr_norm #(.BITWR_CMD(BITWR_CMD)) u_norm (
    .cmd(req_cmd), .addr_in(req_addr), .addr_out(fwd_addr)
  );

  always_comb begin
    dup_d  = dup_q | dup_block;
    orph_d = orph_q | orphan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dup_q  <= 1'b0;
      orph_q <= 1'b0;
    end else begin
      dup_q  <= dup_d;
      orph_q <= orph_d;
    end
  end

  assign dup_err    = dup_q;
  assign orphan_err = orph_q;
endmodule

// File: rtl/mreq_tag_guard_chk.sv
module mreq_tag_guard_chk
  import mreq_pkg::*;
#(
  parameter logic [CMD_W-1:0] BITWR_CMD = 6'h11
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_posted,
  input logic [TAG_W-1:0]  req_tag,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [CMD_W-1:0]  fwd_cmd,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              rsp_valid,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [CNT_W-1:0]  live_count,
  input logic              dup_err,
  input logic              orphan_err,
  input logic              proto_err,
  input logic              in_burst,
  input logic [NTAGS-1:0]  inuse
);
  logic first_np;
  assign first_np = req_valid & req_ready & ~req_posted & ~in_burst;

  assert_accept_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> fwd_valid && fwd_ready);

  assert_claim_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    first_np |=> inuse[$past(req_tag)]);

  assert_count_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_count == CNT_W'($countones(inuse)));

  assert_dup_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && fwd_ready && !req_ready |=> dup_err);

  assert_dup_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);

  assert_free_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && inuse[rsp_tag] && !(first_np && req_tag == rsp_tag)
    |=> !inuse[$past(rsp_tag)]);

  assert_orphan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !inuse[rsp_tag] |=> orphan_err);

  assert_proto_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !req_valid |=> proto_err);

  assert_proto_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_addr_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_cmd != BITWR_CMD |-> fwd_addr[3:0] == 4'h0);
endmodule

bind mreq_tag_guard mreq_tag_guard_chk #(.BITWR_CMD(BITWR_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_posted(req_posted), .req_tag(req_tag), .fwd_valid(fwd_valid),
  .fwd_ready(fwd_ready), .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .live_count(live_count),
  .dup_err(dup_err), .orphan_err(orphan_err), .proto_err(proto_err),
  .in_burst(in_burst), .inuse(u_pool.inuse_q)
);

// File: tb/sim_mreq_tag_guard.sv
module sim_mreq_tag_guard;
  logic        clk, rst_n;
  logic        req_valid, req_posted, req_last, req_ready;
  logic [8:0]  req_tag;
  logic [5:0]  req_cmd;
  logic [2:0]  req_cube;
  logic [33:0] req_addr;
  logic        fwd_valid, fwd_ready;
  logic [8:0]  fwd_tag;
  logic [5:0]  fwd_cmd;
  logic [2:0]  fwd_cube;
  logic [33:0] fwd_addr;
  logic        rsp_valid;
  logic [8:0]  rsp_tag;
  logic [9:0]  live_count;
  logic        dup_err, orphan_err, proto_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  mreq_tag_guard u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit v, input bit p, input bit l, input int tag,
                     input int cmd, input int cube, input longint addr);
    req_valid = v; req_posted = p; req_last = l;
    req_tag = 9'(tag); req_cmd = 6'(cmd); req_cube = 3'(cube); req_addr = 34'(addr);
  endtask

  task automatic idle();
    put(0, 0, 1, 0, 0, 0, 0);
    rsp_valid = 1'b0; rsp_tag = '0;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    idle(); fwd_ready = 1'b1; rst_n = 1'b0;
    step(); step(); rst_n = 1'b1; step();
    chk(live_count == 0, "R12 count after reset", live_count, 0);
    chk({dup_err, orphan_err, proto_err} == 3'b000, "R12 flags after reset",
        {dup_err, orphan_err, proto_err}, 0);
  endtask

  task automatic t_claim();
    put(1, 0, 1, 5, 6'h01, 3, 34'h2_1234_56AB); #2;
    chk(req_ready && fwd_valid, "R1 handshake", {req_ready, fwd_valid}, 3);
    chk(fwd_tag == 5 && fwd_cmd == 1 && fwd_cube == 3, "R1 fields",
        {fwd_tag, fwd_cmd, fwd_cube}, {9'd5, 6'd1, 3'd3});
    chk(fwd_addr == 34'h2_1234_56A0, "R10 nibble cleared", fwd_addr, 34'h2_1234_56A0);
    step(); idle();
    chk(live_count == 1, "R2 claim count", live_count, 1);
    fwd_ready = 1'b0; put(1, 0, 1, 6, 1, 0, 0); #2;
    chk(!req_ready, "R1 ready follows fwd_ready", req_ready, 0);
    step(); idle(); fwd_ready = 1'b1;
    chk(live_count == 1, "R2 no claim while stalled", live_count, 1);
  endtask

  task automatic t_dup();
    put(1, 0, 1, 5, 1, 0, 0); #2;
    chk(!req_ready && !fwd_valid, "R3 duplicate blocked", {req_ready, fwd_valid}, 0);
    step(); idle();
    chk(dup_err, "R3 dup flag", dup_err, 1);
    chk(live_count == 1, "R3 count unchanged", live_count, 1);
    put(1, 0, 1, 7, 1, 0, 0); step();
    #2;
    chk(!req_ready, "R11 back-to-back same tag blocked", req_ready, 0);
    step(); idle();
    chk(live_count == 2, "R11 only first claimed", live_count, 2);
  endtask

  task automatic t_posted();
    put(1, 1, 1, 5, 1, 0, 0); #2;
    chk(req_ready && fwd_valid, "R4 posted passes live tag", {req_ready, fwd_valid}, 3);
    step(); idle();
    chk(live_count == 2, "R4 posted no claim", live_count, 2);
  endtask

  task automatic t_free();
    rsp_valid = 1'b1; rsp_tag = 9'd5; step(); idle();
    chk(live_count == 1, "R5 free decrements", live_count, 1);
    put(1, 0, 1, 5, 1, 0, 0); #2;
    chk(req_ready, "R5 freed tag reusable", req_ready, 1);
    step(); idle();
    chk(live_count == 2, "R5 reclaim", live_count, 2);
    rsp_valid = 1'b1; rsp_tag = 9'd5; step(); idle();
    chk(live_count == 1, "R5 second free", live_count, 1);
  endtask

  task automatic t_orphan();
    chk(!orphan_err, "R6 no orphan yet", orphan_err, 0);
    rsp_valid = 1'b1; rsp_tag = 9'd100; step(); idle();
    chk(orphan_err, "R6 orphan flag", orphan_err, 1);
    chk(live_count == 1, "R6 count unchanged", live_count, 1);
  endtask

  task automatic t_same();
    put(1, 0, 1, 7, 1, 0, 0); rsp_valid = 1'b1; rsp_tag = 9'd7; #2;
    chk(req_ready, "R7 free before check", req_ready, 1);
    step(); idle();
    chk(live_count == 1, "R7 count net zero", live_count, 1);
    rsp_valid = 1'b1; rsp_tag = 9'd7; step(); idle();
    chk(live_count == 0, "R7 tag stayed live", live_count, 0);
  endtask

  task automatic t_bitwr();
    put(1, 1, 1, 0, 6'h11, 0, 34'h3_FFFF_FFAB); #2;
    chk(fwd_addr == 34'h3_FFFF_FFAB, "R10 bit-write keeps nibble", fwd_addr, 34'h3_FFFF_FFAB);
    step(); idle();
  endtask

  task automatic t_burst();
    put(1, 0, 0, 20, 2, 1, 34'h100); step();
    #2; chk(req_ready, "R8 beat two not dup-checked", req_ready, 1);
    fwd_ready = 1'b0; step(); fwd_ready = 1'b1;
    put(1, 0, 1, 20, 2, 1, 34'h100); step(); idle();
    chk(live_count == 1, "R8 one claim per burst", live_count, 1);
    chk(!proto_err, "R9 clean burst", proto_err, 0);
    put(1, 0, 0, 21, 2, 1, 34'h200); step();
    put(1, 0, 0, 21, 2, 1, 34'h210); step();
    put(1, 0, 1, 21, 2, 1, 34'h200); step(); idle();
    chk(proto_err, "R9 field change flagged", proto_err, 1);
    chk(live_count == 2, "R8 second burst claim", live_count, 2);
  endtask

  task automatic t_rereset();
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk(live_count == 0 && !dup_err && !orphan_err && !proto_err, "R12 reset clears",
        {live_count, dup_err, orphan_err, proto_err}, 0);
    put(1, 0, 1, 20, 1, 0, 0); #2;
    chk(req_ready, "R12 tags free after reset", req_ready, 1);
    step(); idle();
  endtask

  initial begin
    t_reset(); t_claim(); t_dup(); t_posted(); t_free();
    t_orphan(); t_same(); t_bitwr(); t_burst(); t_rereset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule